// File: doc/BRIEF.md
# Expansion Slot Configuration Access and Channel-Check Locator

This block sits between a host register port and the configuration byte banks of an eight-slot expansion backplane. Software first parks the motherboard setup register at all ones. It then writes a slot number, together with an enable bit, into the adapter setup register. After that, eight consecutive window addresses reach bytes 0 to 7 of the selected slot's bank. Writing zero to the adapter setup register closes the window again.

When a non-maskable interrupt needs attributing, software pulses a start input. A hardware walker then visits every slot from the lowest index upward, one slot per clock. In byte 5 of each slot it tests two active-low flags: a channel-check flag and a status-valid flag. It collects every checking slot in a mask and reports the first one, numbered from 1. When that slot's status-valid flag is asserted, the walker also keeps that slot's bytes 6 and 7. At the end of the walk it routes the interrupt either to an adapter or, when no slot is checking, to the base platform.

Top module: `slot_cfg_scan`

## Requirements
- R1: After reset, both setup registers read 0x00, the walker is idle with `scan_done` low, `chk_mask` and `first_slot` are 0, both interrupt outputs are low, and every window address reads 0xFF.
- R2: Address 1 is the adapter setup register. Bits 2:0 hold the slot number and bit 3 is the enable. Wider slot values wrap modulo 8, because only the low three bits are kept. A read returns {0000, enable, slot}.
- R3: Window access is open only while the enable bit is 1 and the motherboard setup register (address 0) holds 0xFF. While closed, window reads return 0xFF and window writes leave the banks unchanged.
- R4: While access is open, addresses 8 to 15 read and write bytes 0 to 7 of the selected slot. Each slot keeps its own bytes. Banks reset to 0xFF.
- R5: Writing 0x00 to address 1 ends window access.
- R6: A `scan_start` pulse sampled while the walker is idle raises `scan_busy` for exactly 8 cycles. `scan_done` is then high for one cycle, in the first cycle after `scan_busy` falls. A start sampled during a walk is ignored.
- R7: After a walk, bit i of `chk_mask` is 1 exactly when bit 7 of slot i's byte 5 is 0.
- R8: `first_slot` is one plus the lowest index of a checking slot, or 0 when no slot is checking.
- R9: `ext_valid` is 1 when a first slot exists and bit 6 of its byte 5 is 0. In that case `ext_pos6` and `ext_pos7` carry that slot's bytes 6 and 7. Otherwise all three outputs are 0.
- R10: After a walk, `nmi_slot` is 1 if any slot is checking and `nmi_base` is 1 if none is. Both outputs are low during a walk and from reset until the first walk completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 4 | Host address: 0 motherboard setup, 1 adapter setup, 8-15 window |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data (combinational from address) |
| scan_start | input | 1 | Start a channel-check walk |
| scan_busy | output | 1 | Walk in progress |
| scan_done | output | 1 | One-cycle pulse at walk completion |
| chk_mask | output | 8 | Slots found checking, bit i for slot i |
| first_slot | output | 4 | First checking slot, numbered from 1; 0 if none |
| ext_valid | output | 1 | Extended status captured for the first slot |
| ext_pos6 | output | 8 | Captured byte 6 of the first slot |
| ext_pos7 | output | 8 | Captured byte 7 of the first slot |
| nmi_slot | output | 1 | Interrupt attributed to an adapter |
| nmi_base | output | 1 | Interrupt attributed to the base platform |

## Verification
The bench sweeps all 256 patterns of checking slots, each paired with a varied status-valid pattern. This exposes a walker that reports the last checking slot instead of the first, that is off by one in its 1-based numbering, or that drops slot 7 by ending one cycle early. It probes the closed-window cases too. If the motherboard register is not 0xFF, or the enable is clear, a leaky design would show the written byte or would corrupt a bank. A setup value above 7 catches a design that fails to wrap the slot number and addresses outside the eight banks. A second start during a walk catches a walker that restarts and so runs longer than eight cycles.

// File: rtl/slot_cfg_pkg.sv
package slot_cfg_pkg;
   // Byte positions inside each slot bank that the walker decodes
   localparam int POS_CHK_BYTE = 5;
   localparam int POS_ST6      = 6;
   localparam int POS_ST7      = 7;
   // Active-low flag positions within byte 5
   localparam int CHK_BIT      = 7;
   localparam int STAT_BIT     = 6;
   // Host register addresses
   localparam int MB_ADDR      = 0;
   localparam int AD_ADDR      = 1;

   typedef enum logic {SC_IDLE = 1'b0, SC_WALK = 1'b1} scan_state_e;
endpackage

// File: rtl/slot_pos_bank.sv
module slot_pos_bank
   import slot_cfg_pkg::*;
#(
   parameter int SLOTS = 8,
   parameter int BYTES = 8,
   parameter int DW    = 8,
   localparam int SW   = $clog2(SLOTS),
   localparam int BW   = $clog2(BYTES)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [SW-1:0]              wr_slot,
   input  logic [BW-1:0]              wr_byte,
   input  logic [DW-1:0]              wr_data,
   input  logic [SW-1:0]              rd_slot,
   input  logic [BW-1:0]              rd_byte,
   output logic [DW-1:0]              rd_data,
   input  logic [SW-1:0]              scan_slot,
   output logic [DW-1:0]              scan_b6,
   output logic [DW-1:0]              scan_b7,
   output logic [SLOTS-1:0][DW-1:0]   pos5_all
);
   logic [DW-1:0] mem [SLOTS][BYTES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SLOTS; s++)
            for (int b = 0; b < BYTES; b++)
               mem[s][b] <= '1;
      end else if (wr_en) begin
         mem[wr_slot][wr_byte] <= wr_data;
      end
   end

   assign rd_data = mem[rd_slot][rd_byte];
   assign scan_b6 = mem[scan_slot][POS_ST6];
   assign scan_b7 = mem[scan_slot][POS_ST7];

   for (genvar s = 0; s < SLOTS; s++) begin : g_pos5
      assign pos5_all[s] = mem[s][POS_CHK_BYTE];
   end
endmodule

// File: rtl/slot_chk_scanner.sv
module slot_chk_scanner
   import slot_cfg_pkg::*;
#(
   parameter int SLOTS = 8,
   parameter int DW    = 8,
   localparam int SW   = $clog2(SLOTS),
   localparam int FW   = $clog2(SLOTS + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [SLOTS-1:0][DW-1:0] pos5_all,
   input  logic [DW-1:0]            st6,
   input  logic [DW-1:0]            st7,
   output logic [SW-1:0]            scan_slot,
   output logic                     busy,
   output logic                     done,
   output logic [SLOTS-1:0]         mask,
   output logic [FW-1:0]            first,
   output logic                     ext_valid,
   output logic [DW-1:0]            ext6,
   output logic [DW-1:0]            ext7,
   output logic                     nmi_slot,
   output logic                     nmi_base
);
   scan_state_e      st;
   logic [SW-1:0]    idx;
   logic             found;
   logic [DW-1:0]    cur;
   logic             hit, stat_ok, last;
   logic [SLOTS-1:0] mask_nx;

   assign cur     = pos5_all[idx];
   assign hit     = ~cur[CHK_BIT];
   assign stat_ok = ~cur[STAT_BIT];
   assign last    = (idx == SW'(SLOTS - 1));

   always_comb begin
      mask_nx = mask;
      if (hit) mask_nx[idx] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= SC_IDLE;
         idx       <= '0;
         found     <= 1'b0;
         mask      <= '0;
         first     <= '0;
         ext_valid <= 1'b0;
         ext6      <= '0;
         ext7      <= '0;
         done      <= 1'b0;
         nmi_slot  <= 1'b0;
         nmi_base  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            SC_IDLE: begin
               if (start) begin
                  st        <= SC_WALK;
                  idx       <= '0;
                  found     <= 1'b0;
                  mask      <= '0;
                  first     <= '0;
                  ext_valid <= 1'b0;
                  ext6      <= '0;
                  ext7      <= '0;
                  nmi_slot  <= 1'b0;
                  nmi_base  <= 1'b0;
               end
            end
            SC_WALK: begin
               mask <= mask_nx;
               if (hit && !found) begin
                  found <= 1'b1;
                  first <= FW'(idx) + FW'(1);
                  if (stat_ok) begin
                     ext_valid <= 1'b1;
                     ext6      <= st6;
                     ext7      <= st7;
                  end
               end
               idx <= idx + SW'(1);
               if (last) begin
                  st       <= SC_IDLE;
                  done     <= 1'b1;
                  nmi_slot <= |mask_nx;
                  nmi_base <= ~|mask_nx;
               end
            end
            default: st <= SC_IDLE;
         endcase
      end
   end

   assign busy      = (st == SC_WALK);
   assign scan_slot = idx;
endmodule

// File: rtl/slot_cfg_scan.sv
module slot_cfg_scan
   import slot_cfg_pkg::*;
#(
   parameter int SLOTS     = 8,
   parameter int POS_BYTES = 8,
   parameter int DW        = 8,
   localparam int SW       = $clog2(SLOTS),
   localparam int BW       = $clog2(POS_BYTES),
   localparam int AW       = BW + 1,
   localparam int FW       = $clog2(SLOTS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [AW-1:0]    reg_addr,
   input  logic [DW-1:0]    reg_wdata,
   output logic [DW-1:0]    reg_rdata,
   input  logic             scan_start,
   output logic             scan_busy,
   output logic             scan_done,
   output logic [SLOTS-1:0] chk_mask,
   output logic [FW-1:0]    first_slot,
   output logic             ext_valid,
   output logic [DW-1:0]    ext_pos6,
   output logic [DW-1:0]    ext_pos7,
   output logic             nmi_slot,
   output logic             nmi_base
);
   // Elaboration-time parameter checks
   if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("SLOTS must be a power of two, at least 2");
   end
   if (POS_BYTES < 8 || (POS_BYTES & (POS_BYTES - 1)) != 0) begin : g_bad_bytes
      $error("POS_BYTES must be a power of two, at least 8");
   end
   if (DW < 8 || SW >= DW) begin : g_bad_dw
      $error("DW must be at least 8 and wider than the slot field");
   end

   logic [DW-1:0]            mb_q;
   logic                     ad_en_q;
   logic [SW-1:0]            ad_slot_q;
   logic                     access_ok, in_win;
   logic [BW-1:0]            win_byte;
   logic [DW-1:0]            bank_rd, b6, b7;
   logic [SW-1:0]            walk_slot;
   logic [SLOTS-1:0][DW-1:0] pos5_all;

   assign access_ok = ad_en_q && (mb_q == {DW{1'b1}});
   assign in_win    = reg_addr[AW-1];
   assign win_byte  = reg_addr[BW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mb_q      <= '0;
         ad_en_q   <= 1'b0;
         ad_slot_q <= '0;
      end else if (reg_wr) begin
         if (reg_addr == AW'(MB_ADDR)) mb_q <= reg_wdata;
         if (reg_addr == AW'(AD_ADDR)) begin
            ad_slot_q <= reg_wdata[SW-1:0];
            ad_en_q   <= reg_wdata[SW];
         end
      end
   end

   always_comb begin
      reg_rdata = '1;
      if (reg_addr == AW'(MB_ADDR))      reg_rdata = mb_q;
      else if (reg_addr == AW'(AD_ADDR)) reg_rdata = DW'({ad_en_q, ad_slot_q});
      else if (in_win && access_ok)      reg_rdata = bank_rd;
   end

   slot_pos_bank #(.SLOTS(SLOTS), .BYTES(POS_BYTES), .DW(DW)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr && in_win && access_ok),
      .wr_slot   (ad_slot_q),
      .wr_byte   (win_byte),
      .wr_data   (reg_wdata),
      .rd_slot   (ad_slot_q),
      .rd_byte   (win_byte),
      .rd_data   (bank_rd),
      .scan_slot (walk_slot),
      .scan_b6   (b6),
      .scan_b7   (b7),
      .pos5_all  (pos5_all)
   );

   slot_chk_scanner #(.SLOTS(SLOTS), .DW(DW)) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (scan_start),
      .pos5_all  (pos5_all),
      .st6       (b6),
      .st7       (b7),
      .scan_slot (walk_slot),
      .busy      (scan_busy),
      .done      (scan_done),
      .mask      (chk_mask),
      .first     (first_slot),
      .ext_valid (ext_valid),
      .ext6      (ext_pos6),
      .ext7      (ext_pos7),
      .nmi_slot  (nmi_slot),
      .nmi_base  (nmi_base)
   );
endmodule

// File: rtl/slot_cfg_scan_chk.sv
module slot_cfg_scan_chk #(
   parameter int SLOTS = 8,
   localparam int FW   = $clog2(SLOTS + 1),
   localparam int CW   = $clog2(SLOTS + 2)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scan_busy,
   input logic             scan_done,
   input logic [SLOTS-1:0] chk_mask,
   input logic [FW-1:0]    first_slot,
   input logic             ext_valid,
   input logic             nmi_slot,
   input logic             nmi_base
);
   logic [CW-1:0]    busy_cnt;
   logic [SLOTS-1:0] below;
   logic             first_bit;

   always_ff @(posedge clk) begin
      if (!rst_n)         busy_cnt <= '0;
      else if (scan_busy) busy_cnt <= busy_cnt + CW'(1);
      else                busy_cnt <= '0;
   end

   always_comb begin
      below     = '0;
      first_bit = 1'b0;
      for (int i = 0; i < SLOTS; i++) begin
         if ((i + 1) < int'(first_slot))  below[i]  = 1'b1;
         if ((i + 1) == int'(first_slot)) first_bit = chk_mask[i];
      end
   end

   a_r6_walk_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scan_busy) |-> (busy_cnt == CW'(SLOTS)));

   a_r6_done_after_walk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |-> (!scan_busy && $past(scan_busy)));

   a_r10_nmi_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(nmi_slot && nmi_base));

   a_r10_quiet_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_busy |-> !(nmi_slot || nmi_base));

   a_r10_nmi_follows_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_slot || nmi_base) |-> (nmi_slot == (|chk_mask)));

   a_r8_first_is_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      (!scan_busy && first_slot != '0) |-> (first_bit && ((chk_mask & below) == '0)));

   a_r9_ext_needs_first: assert property (@(posedge clk) disable iff (!rst_n)
      ext_valid |-> (first_slot != '0));
endmodule

bind slot_cfg_scan slot_cfg_scan_chk #(.SLOTS(SLOTS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .scan_busy  (scan_busy),
   .scan_done  (scan_done),
   .chk_mask   (chk_mask),
   .first_slot (first_slot),
   .ext_valid  (ext_valid),
   .nmi_slot   (nmi_slot),
   .nmi_base   (nmi_base)
);

// File: tb/slot_cfg_scan_tb.sv
module slot_cfg_scan_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       scan_start = 1'b0;
   logic       scan_busy, scan_done, ext_valid, nmi_slot, nmi_base;
   logic [7:0] chk_mask, ext_pos6, ext_pos7;
   logic [3:0] first_slot;

   int nvec = 0;
   int nerr = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   slot_cfg_scan u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scan_start(scan_start),
      .scan_busy(scan_busy), .scan_done(scan_done), .chk_mask(chk_mask),
      .first_slot(first_slot), .ext_valid(ext_valid), .ext_pos6(ext_pos6),
      .ext_pos7(ext_pos7), .nmi_slot(nmi_slot), .nmi_base(nmi_base)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      nvec++;
      if (got !== exp) begin
         nerr++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   function automatic logic [7:0] pat(input int s, input int b);
      return 8'((s << 4) | b) ^ 8'hA5;
   endfunction

   task automatic run_scan(input bit poke, output int len, output bit done_ok);
      @(negedge clk); scan_start = 1'b1;
      @(negedge clk); scan_start = 1'b0;
      len = 0;
      while (scan_busy && len < 100) begin
         len++;
         scan_start = (poke && len == 3);
         @(negedge clk);
      end
      scan_start = 1'b0;
      done_ok = scan_done;
      @(negedge clk);
      done_ok = done_ok && !scan_done && !scan_busy;
   endtask

   initial begin : watchdog
      #(8 * 200000);
      if (!finished) begin
         nvec++; nerr++;
         $display("FAIL watchdog: got 0x0 expected 0x1");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] d;
      int len;
      bit dok;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 busy", scan_busy, 0);
      chk("R1 done", scan_done, 0);
      chk("R1 mask", chk_mask, 0);
      chk("R1 first", first_slot, 0);
      chk("R1 nmi", {nmi_slot, nmi_base}, 0);
      rd(4'd0, d); chk("R1 mb setup", d, 8'h00);
      rd(4'd1, d); chk("R1 adapter setup", d, 8'h00);
      rd(4'd13, d); chk("R1 window", d, 8'hFF);

      // R3: enable set but motherboard register not 0xFF
      wr(4'd1, 8'h0B);
      wr(4'd10, 8'h12);
      rd(4'd10, d); chk("R3 read closed (mb)", d, 8'hFF);
      wr(4'd0, 8'hFF);
      rd(4'd10, d); chk("R3 closed write ignored", d, 8'hFF);
      rd(4'd1, d); chk("R2 setup readback", d, 8'h0B);

      // R4: full sweep of all slots and bytes
      for (int s = 0; s < 8; s++) begin
         wr(4'd1, 8'(8 | s));
         for (int b = 0; b < 8; b++) wr(4'(8 + b), pat(s, b));
      end
      for (int s = 0; s < 8; s++) begin
         wr(4'd1, 8'(8 | s));
         for (int b = 0; b < 8; b++) begin
            rd(4'(8 + b), d); chk($sformatf("R4 slot%0d byte%0d", s, b), d, pat(s, b));
         end
      end

      // R2: slot number wraps modulo 8
      wr(4'd1, 8'h1D);
      rd(4'd1, d); chk("R2 wrapped readback", d, 8'h0D);
      rd(4'd11, d); chk("R2 wrapped slot select", d, pat(5, 3));

      // R5: writing zero closes the window
      wr(4'd1, 8'h00);
      rd(4'd11, d); chk("R5 closed read", d, 8'hFF);
      wr(4'd11, 8'h00);
      wr(4'd1, 8'h0D);
      rd(4'd11, d); chk("R5 closed write ignored", d, pat(5, 3));

      // R3: motherboard register not all ones closes access
      wr(4'd0, 8'h7F);
      rd(4'd11, d); chk("R3 mb 7F read", d, 8'hFF);
      wr(4'd11, 8'h3C);
      wr(4'd0, 8'hFF);
      rd(4'd11, d); chk("R3 mb 7F write ignored", d, pat(5, 3));

      // R6..R10: every checking pattern
      for (int p = 0; p < 256; p++) begin
         logic [7:0] pm, em;
         int ef;
         bit ex;
         pm = 8'(p);
         em = 8'(p * 37) ^ 8'h5C;
         for (int s = 0; s < 8; s++) begin
            wr(4'd1, 8'(8 | s));
            wr(4'd13, {~pm[s], ~em[s], 6'h15});
         end
         wr(4'd1, 8'h00);
         ef = 0;
         for (int s = 7; s >= 0; s--) if (pm[s]) ef = s + 1;
         ex = (ef != 0) && em[ef - 1];
         run_scan(p % 16 == 0, len, dok);
         chk($sformatf("R6 walk length p=%0d", p), len, 8);
         chk($sformatf("R6 done pulse p=%0d", p), dok, 1);
         chk($sformatf("R7 mask p=%0d", p), chk_mask, pm);
         chk($sformatf("R8 first p=%0d", p), first_slot, ef);
         chk($sformatf("R9 ext p=%0d", p), ext_valid, ex);
         chk($sformatf("R9 byte6 p=%0d", p), ext_pos6, ex ? pat(ef - 1, 6) : 8'h00);
         chk($sformatf("R9 byte7 p=%0d", p), ext_pos7, ex ? pat(ef - 1, 7) : 8'h00);
         chk($sformatf("R10 nmi_slot p=%0d", p), nmi_slot, pm != 0);
         chk($sformatf("R10 nmi_base p=%0d", p), nmi_base, pm == 0);
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule